// File: doc/BRIEF.md
# Predication register redirection table

The block keeps sixteen software-written configuration words. Each word binds one architectural register, in either the integer or the floating-point file, to a predication setup. The setup names the register that holds the element mask, and whether that mask is complemented when it is used. It also says whether masked-off element positions are zeroed. The words form a key-value store. The block turns this store around into a per-register table, with one record for each of the 32 registers in each file, so the decode stage can ask about a register directly.

Decode presents a destination register number and a file select. In the same cycle it gets back whether the register is predicated, the 6-bit address of the mask register, and the invert and zeroing flags. The block only reports these flags. It never reads a register file and never applies a mask. Software can read every configuration word back.

Top module: `pred_redirect`

## Requirements
- R1: After reset every record in both files reads as not enabled, and every configuration word reads back as zero.
- R2: A configuration word is 14 bits, laid out as follows: mask register index in [4:0], keyed register in [9:5], file select in [10] (0 integer, 1 floating-point), invert in [11], zeroing in [12] and bank in [13].
- R3: From the first clock edge that samples a write, a query of the keyed register in the selected file returns enabled, together with the word's mask index, invert and zeroing values.
- R4: The integer and floating-point tables are separate, so a word keyed to register n of one file leaves register n of the other file unchanged.
- R5: When several valid words key the same register of the same file, the record follows the highest-numbered of them, whichever was written last.
- R6: Overwriting a word releases the record it previously keyed. That record becomes not enabled, unless a lower-numbered word still keys it, in which case it follows that word.
- R7: The query is combinational: a change of register number or file select alters the outputs without a clock edge.
- R8: The mask address output is 6 bits wide, with the bank field as bit 5 and the mask index as bits 4:0.
- R9: A configuration word reads back, through the combinational readback port, the value last written to it.
- R10: A query of a register that is not enabled returns zero mask address, invert and zeroing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_waddr_i | input | 4 | Configuration word to write |
| cfg_wdata_i | input | 14 | Word value to write |
| cfg_raddr_i | input | 4 | Configuration word to read back |
| cfg_rdata_o | output | 14 | Readback value |
| q_reg_i | input | 5 | Queried register number |
| q_fp_i | input | 1 | Queried file: 0 integer, 1 floating-point |
| q_en_o | output | 1 | Queried register is predicated |
| q_mask_reg_o | output | 6 | Mask register address, bank as MSB |
| q_inv_o | output | 1 | Mask is complemented on use |
| q_zero_o | output | 1 | Masked-off elements are zeroed |

## Verification
The clocked properties assume the write strobe, the addresses and the query inputs are known at every sampled edge, and the stability check also assumes the query inputs change only away from the edge. The bench keeps the strobe low through reset, and it changes every input only at falling edges. The enable property compares a query against the word written one edge earlier. It therefore relies on the bench either holding or deliberately choosing the query register around writes, and every scenario task sets the query after the write has landed.

// File: rtl/pred_redirect_pkg.sv
package pred_redirect_pkg;
  localparam int REG_AW  = 5;
  localparam int NUM_REGS = 1 << REG_AW;
  localparam int ENTRY_W = 2 * REG_AW + 4;
  localparam int F_KEY   = REG_AW;
  localparam int F_FP    = 2 * REG_AW;
  localparam int F_INV   = F_FP + 1;
  localparam int F_ZERO  = F_FP + 2;
  localparam int F_BANK  = F_FP + 3;

  typedef logic [ENTRY_W-1:0] entry_t;

  typedef struct packed {
    logic              en;
    logic              bank;
    logic              zero;
    logic              inv;
    logic [REG_AW-1:0] idx;
  } pred_rec_t;

  function automatic logic [REG_AW-1:0] ent_key(entry_t e);
    return e[F_KEY +: REG_AW];
  endfunction

  function automatic pred_rec_t ent_to_rec(entry_t e);
    pred_rec_t r;
    r.en   = 1'b1;
    r.bank = e[F_BANK];
    r.zero = e[F_ZERO];
    r.inv  = e[F_INV];
    r.idx  = e[REG_AW-1:0];
    return r;
  endfunction
endpackage

// File: rtl/pred_cfg_store.sv
module pred_cfg_store
  import pred_redirect_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int EAW = $clog2(NUM_ENTRIES)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [EAW-1:0]                      waddr_i,
  input  entry_t                              wdata_i,
  input  logic [EAW-1:0]                      raddr_i,
  output entry_t                              rdata_o,
  output logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] ent_nxt_o,
  output logic [NUM_ENTRIES-1:0]              vld_nxt_o
);
  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] ent_q, ent_d;
  logic [NUM_ENTRIES-1:0]              vld_q, vld_d;

  always_comb begin
    ent_d = ent_q;
    vld_d = vld_q;
    if (we_i) begin
      ent_d[waddr_i] = wdata_i;
      vld_d[waddr_i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
      vld_q <= '0;
    end else begin
      ent_q <= ent_d;
      vld_q <= vld_d;
    end
  end

  assign rdata_o   = ent_q[raddr_i];
  assign ent_nxt_o = ent_d;
  assign vld_nxt_o = vld_d;
endmodule

// File: rtl/pred_table_build.sv
module pred_table_build
  import pred_redirect_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] ent_i,
  input  logic [NUM_ENTRIES-1:0]              vld_i,
  output pred_rec_t [1:0][NUM_REGS-1:0]       tbl_o
);
  pred_rec_t [1:0][NUM_REGS-1:0] tbl_q, tbl_d;

  for (genvar f = 0; f < 2; f++) begin : g_file
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      // ascending scan: highest-numbered matching entry is left standing
      always_comb begin
        tbl_d[f][r] = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (vld_i[e] && (ent_i[e][F_FP] == 1'(f)) &&
              (ent_key(ent_i[e]) == REG_AW'(r)))
            tbl_d[f][r] = ent_to_rec(ent_i[e]);
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tbl_q[f][r] <= '0;
        else         tbl_q[f][r] <= tbl_d[f][r];
      end
    end
  end

  assign tbl_o = tbl_q;
endmodule

// File: rtl/pred_query_mux.sv
module pred_query_mux
  import pred_redirect_pkg::*;
(
  input  pred_rec_t [1:0][NUM_REGS-1:0] tbl_i,
  input  logic [REG_AW-1:0]             reg_i,
  input  logic                          fp_i,
  output logic                          en_o,
  output logic [REG_AW:0]               mask_reg_o,
  output logic                          inv_o,
  output logic                          zero_o
);
  pred_rec_t rec;

  assign rec        = tbl_i[fp_i][reg_i];
  assign en_o       = rec.en;
  assign mask_reg_o = {rec.bank, rec.idx};
  assign inv_o      = rec.inv;
  assign zero_o     = rec.zero;
endmodule

// File: rtl/pred_redirect.sv
module pred_redirect
  import pred_redirect_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int EAW = $clog2(NUM_ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [EAW-1:0]     cfg_waddr_i,
  input  logic [ENTRY_W-1:0] cfg_wdata_i,
  input  logic [EAW-1:0]     cfg_raddr_i,
  output logic [ENTRY_W-1:0] cfg_rdata_o,
  input  logic [REG_AW-1:0]  q_reg_i,
  input  logic               q_fp_i,
  output logic               q_en_o,
  output logic [REG_AW:0]    q_mask_reg_o,
  output logic               q_inv_o,
  output logic               q_zero_o
);
  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] ent_nxt;
  logic [NUM_ENTRIES-1:0]              vld_nxt;
  pred_rec_t [1:0][NUM_REGS-1:0]       tbl;

  pred_cfg_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .waddr_i   (cfg_waddr_i),
    .wdata_i   (cfg_wdata_i),
    .raddr_i   (cfg_raddr_i),
    .rdata_o   (cfg_rdata_o),
    .ent_nxt_o (ent_nxt),
    .vld_nxt_o (vld_nxt)
  );

  pred_table_build #(.NUM_ENTRIES(NUM_ENTRIES)) u_build (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ent_i  (ent_nxt),
    .vld_i  (vld_nxt),
    .tbl_o  (tbl)
  );

  pred_query_mux u_query (
    .tbl_i      (tbl),
    .reg_i      (q_reg_i),
    .fp_i       (q_fp_i),
    .en_o       (q_en_o),
    .mask_reg_o (q_mask_reg_o),
    .inv_o      (q_inv_o),
    .zero_o     (q_zero_o)
  );
endmodule

// File: rtl/pred_redirect_chk.sv
module pred_redirect_chk
  import pred_redirect_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int EAW = $clog2(NUM_ENTRIES)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [EAW-1:0]     cfg_waddr_i,
  input logic [ENTRY_W-1:0] cfg_wdata_i,
  input logic [EAW-1:0]     cfg_raddr_i,
  input logic [ENTRY_W-1:0] cfg_rdata_o,
  input logic [REG_AW-1:0]  q_reg_i,
  input logic               q_fp_i,
  input logic               q_en_o,
  input logic [REG_AW:0]    q_mask_reg_o,
  input logic               q_inv_o,
  input logic               q_zero_o
);
  AST_WRITE_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_we_i) && q_reg_i == $past(cfg_wdata_i[F_KEY +: REG_AW]) &&
     q_fp_i == $past(cfg_wdata_i[F_FP])) |-> q_en_o); // R3

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_en_o |-> (q_mask_reg_o == '0 && !q_inv_o && !q_zero_o)); // R10

  AST_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_we_i) && cfg_raddr_i == $past(cfg_waddr_i)) |->
      cfg_rdata_o == $past(cfg_wdata_i)); // R9

  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cfg_we_i) && $stable(q_reg_i) && $stable(q_fp_i)) |->
      ($stable(q_en_o) && $stable(q_mask_reg_o) &&
       $stable(q_inv_o) && $stable(q_zero_o))); // R7
endmodule

bind pred_redirect pred_redirect_chk #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (.*);

// File: tb/pred_redirect_bench.sv
`timescale 1ns/1ps
module pred_redirect_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_waddr_i = '0;
  logic [13:0] cfg_wdata_i = '0;
  logic [3:0]  cfg_raddr_i = '0;
  logic [13:0] cfg_rdata_o;
  logic [4:0]  q_reg_i = '0;
  logic        q_fp_i = 1'b0;
  logic        q_en_o;
  logic [5:0]  q_mask_reg_o;
  logic        q_inv_o;
  logic        q_zero_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  pred_redirect u_pred_redirect (.*);

  function automatic logic [13:0] mk(bit bank, bit zero, bit inv, bit fp,
                                     int key, int idx);
    return {bank, zero, inv, fp, 5'(key), 5'(idx)};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [13:0] data);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_waddr_i = 4'(addr); cfg_wdata_i = data;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic expq(string req, bit fp, int rg, bit en, int mask, bit inv, bit zero);
    q_fp_i = fp; q_reg_i = 5'(rg);
    #1;
    check(q_en_o == en, req, "enable", int'(q_en_o), int'(en));
    check(q_mask_reg_o == 6'(mask), req, "mask reg", int'(q_mask_reg_o), mask);
    check(q_inv_o == inv, req, "invert", int'(q_inv_o), int'(inv));
    check(q_zero_o == zero, req, "zeroing", int'(q_zero_o), int'(zero));
  endtask

  task automatic exprb(string req, int addr, logic [13:0] exp);
    cfg_raddr_i = 4'(addr);
    #1;
    check(cfg_rdata_o == exp, req, "readback", int'(cfg_rdata_o), int'(exp));
  endtask

  task automatic t_reset;
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 32; r++) begin
        q_fp_i = f[0]; q_reg_i = 5'(r); #0.1;
        check(!q_en_o, "R1", "record enabled after reset", int'(q_en_o), 0);
      end
    for (int e = 0; e < 16; e++) exprb("R1", e, '0);
  endtask

  task automatic t_basic;
    wr(2, mk(0, 1, 0, 0, 9, 17));
    expq("R3", 0, 9, 1, 17, 0, 1);
    exprb("R2", 2, 14'b0_1_0_0_01001_10001);
  endtask

  task automatic t_files;
    expq("R4", 1, 9, 0, 0, 0, 0);
    wr(3, mk(0, 0, 1, 1, 9, 4));
    expq("R4", 1, 9, 1, 4, 1, 0);
    expq("R4", 0, 9, 1, 17, 0, 1);
    expq("R10", 0, 10, 0, 0, 0, 0);
  endtask

  task automatic t_priority;
    wr(10, mk(0, 0, 1, 0, 9, 22));
    expq("R5", 0, 9, 1, 22, 1, 0);
    wr(1, mk(0, 1, 1, 0, 9, 3));
    expq("R5", 0, 9, 1, 22, 1, 0);
  endtask

  task automatic t_release;
    wr(10, mk(0, 0, 0, 0, 12, 5));
    expq("R6", 0, 9, 1, 17, 0, 1);
    expq("R6", 0, 12, 1, 5, 0, 0);
    wr(3, mk(0, 0, 0, 1, 20, 8));
    expq("R6", 1, 9, 0, 0, 0, 0);
    exprb("R9", 10, mk(0, 0, 0, 0, 12, 5));
  endtask

  task automatic t_comb;
    // no clock edge between the two queries
    @(posedge clk_i); #0.5;
    q_fp_i = 1'b0; q_reg_i = 5'd12; #0.5;
    check(q_mask_reg_o == 6'd5, "R7", "mask reg", int'(q_mask_reg_o), 5);
    q_fp_i = 1'b1; q_reg_i = 5'd20; #0.5;
    check(q_mask_reg_o == 6'd8 && q_en_o, "R7", "mask reg", int'(q_mask_reg_o), 8);
  endtask

  task automatic t_bank;
    wr(5, mk(1, 0, 0, 0, 30, 2));
    expq("R8", 0, 30, 1, 34, 0, 0);
    exprb("R8", 5, mk(1, 0, 0, 0, 30, 2));
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_basic();
        t_files();
        t_priority();
        t_release();
        t_comb();
        t_bank();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule